// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Unit

This block watches the bus cycles a processor presents and raises a break request when those cycles meet a programmed condition. It has two channels, and each channel can be set up on its own. A channel compares an address-space ID (ASID) joined to a 32-bit address, with a mask on each address bit. It also checks the kind of cycle, which is either an instruction fetch or an operand access. For operand accesses it can further check the direction and the operand size. Channel 1 adds a data comparison with a mask on each data bit, and it has a repeat count that must run out before the channel counts as hit.

The two channels can act independently or be chained into a sequence. In a sequence, one channel must hit first in one bus cycle, and the other channel must hit in a later bus cycle. The order of the two is selectable. The break request is a registered one-cycle pulse. With the pulse comes the number of the channel that caused it and a timing tag, which asks for the break before or after the matched instruction executes.

Software sets up the unit through a simple register-write port. It reads back one sticky hit flag per channel and clears those flags with a write of one.

Top module: `brk_unit`

Register select codes on `cfg_sel`:
- 0: channel 0 address.
- 1: channel 0 address mask.
- 2: channel 0 control.
- 3: channel 1 address.
- 4: channel 1 address mask.
- 5: channel 1 control.
- 6: channel 1 data.
- 7: channel 1 data mask.
- 8: global register.
- 9: flag clear.

In each mask, a mask bit of 1 means that bit is not compared.

Control word fields:
- [ASIDW-1:0]: ASID value.
- 16: channel enable.
- 17: match instruction fetches (1) or operand accesses (0).
- 18: match reads.
- 19: match writes.
- 20: compare the operand size.
- [22:21]: size code.
- 23: break after execution.
- 24: compare the ASID.
- 25: compare data (channel 1 only).

Global register fields:
- 0: sequence mode.
- 1: order. 0 means channel 0 then channel 1; 1 means channel 1 then channel 0.
- [4+CNT_W-1:4]: repeat count.

## Requirements
- R1: After reset, `brk_req`, `brk_src`, `brk_post` and `hit_flag` are all 0, and every channel is disabled, so no bus cycle raises a break.
- R2: A channel hits when `bus_vld` is high and every address bit whose mask bit is 0 equals the programmed address. A mask of 0xFFF therefore matches a whole 4-Kbyte page. The break pulse appears in the clock cycle after the matching bus cycle.
- R3: With ASID compare (bit 24) set, `bus_asid` must equal the whole programmed ASID. With bit 24 clear, the ASID is ignored entirely.
- R4: A channel hits only the cycle kind selected by bit 17 (`bus_ifetch`). For operand accesses it also requires the direction to be enabled, with bit 18 for reads and bit 19 for writes. When bit 20 is set, `bus_size` must equal the size code, where 0 is byte, 1 is word, 2 is longword and 3 is quadword.
- R5: When bit 25 is set, channel 1 also requires every data bit whose data-mask bit is 0 to equal the programmed data.
- R6: `brk_post` is high with a break only when the causing channel matches instruction fetches and has bit 23 set. For operand breaks it is 0.
- R7: Outside sequence mode, a hit on either channel raises a break. `brk_src` names the channel that caused it, and channel 0 wins when both hit in the same cycle.
- R8: In sequence mode, a hit on the first channel arms the unit. A later hit on the second channel raises a break whose `brk_src` is the second channel, and that break disarms the unit. A second-channel hit in the very cycle that arms does not complete the sequence. The armed state persists across unrelated cycles.
- R9: Channel 1 counts its condition matches, and the counter advances on every match whatever the sequence state. With repeat count N ≥ 2, it hits on every Nth match, then reloads. A count of 0 or 1 hits on every match.
- R10: `hit_flag[c]` is set by each hit of channel c and stays set. A write to select 9 clears the flags whose data bits are 1. A hit in the same cycle as the clear wins, and the flag stays set.
- R11: A write to any select from 0 to 8 disarms the sequence and reloads the channel 1 counter. A bus cycle presented in that same clock cycle is ignored.
- R12: `brk_req` is high for exactly one cycle per qualifying bus cycle. It is never high unless the previous cycle carried a valid bus cycle outside a configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | A bus cycle is present this clock |
| bus_ifetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Operand size code |
| bus_asid | input | ASIDW | Address-space ID of the cycle |
| bus_addr | input | AW | Address of the cycle |
| bus_data | input | DW | Data of the cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| brk_req | output | 1 | One-cycle break request |
| brk_src | output | 1 | Channel that caused the break |
| brk_post | output | 1 | Break after execution (instruction breaks) |
| hit_flag | output | 2 | Sticky per-channel hit flags |

## Verification
The hardest situations to reach from the ports are the sequence corner cases. The first case is a bus cycle that satisfies both channels while the unit is unarmed. The second is a configuration write that lands after arming. To reach them, the stimulus programs the two channels to overlap: one channel is read-only over a 256-byte window, and the other takes reads and writes on a single address inside it. This lets a read hit both channels, a write hit only one, and a read elsewhere hit only the other. The repeat counter is driven through exact match counts around its reload, including a reload forced by a configuration write partway through a count.

// File: rtl/brk_unit.sv
module brk_unit #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int ASIDW = 8,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_vld,
  input  logic             bus_ifetch,
  input  logic             bus_wr,
  input  logic [1:0]       bus_size,
  input  logic [ASIDW-1:0] bus_asid,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic             brk_req,
  output logic             brk_src,
  output logic             brk_post,
  output logic [1:0]       hit_flag
);
  localparam int CTLW   = 26;
  localparam int B_EN   = 16;
  localparam int B_IF   = 17;
  localparam int B_RD   = 18;
  localparam int B_WR   = 19;
  localparam int B_SZEN = 20;
  localparam int B_SZ   = 21;
  localparam int B_POST = 23;
  localparam int B_ASEN = 24;
  localparam int B_DEN  = 25;
  localparam int B_CNT  = 4;

  logic [AW-1:0]   addr_q  [2];
  logic [AW-1:0]   amask_q [2];
  logic [CTLW-1:0] ctl_q   [2];
  logic [DW-1:0]   data_q, dmask_q;
  logic            seq_q, order_q, armed_q;
  logic [CNT_W-1:0] rpt_q, cnt_q;
  logic [1:0]      flag_q, raw;

  wire cfg_hit = cfg_we && (cfg_sel <= 4'd8);
  wire clr_hit = cfg_we && (cfg_sel == 4'd9);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [CTLW-1:0] k;
    logic dir_ok, size_ok, kind_ok, addr_ok, asid_ok, data_ok;
    assign k       = ctl_q[c];
    assign dir_ok  = bus_wr ? k[B_WR] : k[B_RD];
    assign size_ok = !k[B_SZEN] || (bus_size == k[B_SZ +: 2]);
    assign kind_ok = (bus_ifetch == k[B_IF]) && (k[B_IF] || (dir_ok && size_ok));
    assign addr_ok = ((bus_addr ^ addr_q[c]) & ~amask_q[c]) == '0;
    assign asid_ok = !k[B_ASEN] || (bus_asid == k[ASIDW-1:0]);
    if (c == 1) begin : g_data
      assign data_ok = !k[B_DEN] || (((bus_data ^ data_q) & ~dmask_q) == '0);
    end else begin : g_nodata
      assign data_ok = 1'b1;
    end
    assign raw[c] = bus_vld && !cfg_hit && k[B_EN] && kind_ok && addr_ok && asid_ok && data_ok;
  end

  wire unused_bits = &{1'b0, ctl_q[0][B_DEN], ctl_q[0][15:ASIDW], ctl_q[1][15:ASIDW]};

  wire       cnt_done = cnt_q <= CNT_W'(1);
  wire [1:0] ev       = {raw[1] && cnt_done, raw[0]};
  wire       first    = order_q ? ev[1] : ev[0];
  wire       second   = order_q ? ev[0] : ev[1];
  wire       fire     = seq_q ? (armed_q && second) : (|ev);
  wire       src      = seq_q ? !order_q : !ev[0];
  wire       post     = ctl_q[src][B_IF] && ctl_q[src][B_POST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        addr_q[i]  <= '0;
        amask_q[i] <= '0;
        ctl_q[i]   <= '0;
      end
      data_q  <= '0;
      dmask_q <= '0;
      seq_q   <= 1'b0;
      order_q <= 1'b0;
      rpt_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        4'd0: addr_q[0]  <= cfg_wdata[AW-1:0];
        4'd1: amask_q[0] <= cfg_wdata[AW-1:0];
        4'd2: ctl_q[0]   <= cfg_wdata[CTLW-1:0];
        4'd3: addr_q[1]  <= cfg_wdata[AW-1:0];
        4'd4: amask_q[1] <= cfg_wdata[AW-1:0];
        4'd5: ctl_q[1]   <= cfg_wdata[CTLW-1:0];
        4'd6: data_q     <= cfg_wdata[DW-1:0];
        4'd7: dmask_q    <= cfg_wdata[DW-1:0];
        4'd8: begin
          seq_q   <= cfg_wdata[0];
          order_q <= cfg_wdata[1];
          rpt_q   <= cfg_wdata[B_CNT +: CNT_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      flag_q   <= '0;
      brk_req  <= 1'b0;
      brk_src  <= 1'b0;
      brk_post <= 1'b0;
    end else begin
      if (cfg_hit)
        armed_q <= 1'b0;
      else if (!seq_q)
        armed_q <= 1'b0;
      else if (armed_q)
        armed_q <= !second;
      else
        armed_q <= first;

      if (cfg_hit)
        cnt_q <= (cfg_sel == 4'd8) ? cfg_wdata[B_CNT +: CNT_W] : rpt_q;
      else if (raw[1])
        cnt_q <= cnt_done ? rpt_q : cnt_q - CNT_W'(1);

      flag_q   <= (flag_q & ~(clr_hit ? cfg_wdata[1:0] : 2'b00)) | ev;
      brk_req  <= fire;
      brk_src  <= fire && src;
      brk_post <= fire && post;
    end
  end

  assign hit_flag = flag_q;
endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_vld,
  input logic             bus_ifetch,
  input logic             cfg_we,
  input logic [3:0]       cfg_sel,
  input logic [31:0]      cfg_wdata,
  input logic             brk_req,
  input logic             brk_src,
  input logic             brk_post,
  input logic [1:0]       hit_flag,
  input logic             seq_q,
  input logic             order_q,
  input logic             armed_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] rpt_q
);
  // R12
  brk_from_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(bus_vld && !(cfg_we && cfg_sel <= 4'd8)));

  // R6
  post_ifetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_post |-> (brk_req && $past(bus_ifetch)));

  // R10
  flag0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hit_flag[0]) |-> $past(cfg_we && cfg_sel == 4'd9 && cfg_wdata[0]));

  // R10
  flag1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hit_flag[1]) |-> $past(cfg_we && cfg_sel == 4'd9 && cfg_wdata[1]));

  // R8
  seq_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && $past(seq_q)) |-> $past(armed_q));

  // R8
  seq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && $past(seq_q)) |-> (brk_src == !$past(order_q)));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= rpt_q);

  // R11
  cfg_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we && cfg_sel <= 4'd8) |-> (!armed_q && !brk_req));
endmodule

bind brk_unit brk_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_ifetch(bus_ifetch),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .brk_req(brk_req), .brk_src(brk_src), .brk_post(brk_post), .hit_flag(hit_flag),
  .seq_q(seq_q), .order_q(order_q), .armed_q(armed_q), .cnt_q(cnt_q), .rpt_q(rpt_q)
);

// File: tb/test_brk_unit.sv
module test_brk_unit;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_vld = 0, bus_ifetch = 0, bus_wr = 0;
  logic [1:0] bus_size = 0;
  logic [7:0] bus_asid = 0;
  logic [31:0] bus_addr = 0, bus_data = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic brk_req, brk_src, brk_post;
  logic [1:0] hit_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  brk_unit i_brk_unit (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_ifetch(bus_ifetch),
    .bus_wr(bus_wr), .bus_size(bus_size), .bus_asid(bus_asid), .bus_addr(bus_addr),
    .bus_data(bus_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .brk_req(brk_req), .brk_src(brk_src), .brk_post(brk_post), .hit_flag(hit_flag)
  );

  typedef struct packed {
    logic ifetch; logic wr; logic [1:0] sz; logic [7:0] asid;
    logic [31:0] addr; logic [31:0] data; logic eb; logic es; logic ep;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{1'b1, 1'b0, 2'd0, 8'h12, 32'h0000_4ABC, 32'h0,         1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 2'd0, 8'h12, 32'h0000_5000, 32'h0,         1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'd0, 8'h13, 32'h0000_4FFF, 32'h0,         1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 2'd2, 8'h12, 32'h0000_4004, 32'h0,         1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 2'd2, 8'h00, 32'h8000_0010, 32'h1234_56AB, 1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b0, 2'd2, 8'h00, 32'h8000_0010, 32'h1234_56AB, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 2'd1, 8'h00, 32'h8000_0010, 32'h1234_56AB, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 2'd2, 8'h00, 32'h8000_0010, 32'h1234_56AC, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 2'd2, 8'h00, 32'h8000_0014, 32'h0000_00AB, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'd2, 8'h00, 32'h8000_0010, 32'h0000_00AB, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit vld, input bit ifetch, input bit wr, input logic [1:0] sz,
                     input logic [7:0] asid, input logic [31:0] addr, input logic [31:0] data,
                     input bit we, input logic [3:0] sel, input logic [31:0] wd);
    @(negedge clk);
    bus_vld = vld; bus_ifetch = ifetch; bus_wr = wr; bus_size = sz;
    bus_asid = asid; bus_addr = addr; bus_data = data;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(negedge clk);
    bus_vld = 0; cfg_we = 0;
  endtask

  task automatic wcfg(input logic [3:0] sel, input logic [31:0] wd);
    cyc(0, 0, 0, 2'd0, 8'h0, 32'h0, 32'h0, 1, sel, wd);
  endtask

  task automatic op(input bit wr, input logic [31:0] addr);
    cyc(1, 0, wr, 2'd2, 8'h0, addr, 32'h0, 0, 4'd0, 32'h0);
  endtask

  task automatic expect_brk(input string req, input bit b, input bit s, input bit p);
    chk(req, {29'h0, brk_req, brk_src, brk_post}, {29'h0, b, s, p});
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_brk("R1 reset outputs", 0, 0, 0);
    chk("R1 reset flags", {30'h0, hit_flag}, 32'h0);
    rst_n = 1;
    cyc(1, 1, 0, 2'd0, 8'h0, 32'h0, 32'h0, 0, 4'd0, 32'h0);
    expect_brk("R1 disabled channels", 0, 0, 0);

    wcfg(4'd0, 32'h0000_4000); wcfg(4'd1, 32'h0000_0FFF); wcfg(4'd2, 32'h0183_0012);
    wcfg(4'd3, 32'h8000_0010); wcfg(4'd4, 32'h0);         wcfg(4'd5, 32'h0259_0000);
    wcfg(4'd6, 32'h0000_00AB); wcfg(4'd7, 32'hFFFF_FF00); wcfg(4'd8, 32'h0);

    // R2 R3 R4 R5 R6 table of single bus cycles
    for (int i = 0; i < 10; i++) begin
      cyc(1, TBL[i].ifetch, TBL[i].wr, TBL[i].sz, TBL[i].asid, TBL[i].addr, TBL[i].data,
          0, 4'd0, 32'h0);
      expect_brk($sformatf("R2/R3/R4/R5/R6 vector %0d", i), TBL[i].eb, TBL[i].es, TBL[i].ep);
    end

    // R10 sticky flags and clear
    chk("R10 flags set", {30'h0, hit_flag}, 32'h3);
    wcfg(4'd9, 32'h1);
    chk("R10 clear ch0", {30'h0, hit_flag}, 32'h2);
    cyc(1, 1, 0, 2'd0, 8'h12, 32'h0000_4ABC, 32'h0, 1, 4'd9, 32'h3);
    chk("R10 set wins over clear", {30'h0, hit_flag}, 32'h1);
    wcfg(4'd9, 32'h3);
    chk("R10 clear all", {30'h0, hit_flag}, 32'h0);

    // R3 ASID compare off
    wcfg(4'd2, 32'h0083_0012);
    cyc(1, 1, 0, 2'd0, 8'h99, 32'h0000_4ABC, 32'h0, 0, 4'd0, 32'h0);
    expect_brk("R3 ASID ignored", 1, 0, 1);

    // overlapping set-up: ch0 reads 0x100-0x1FF, ch1 reads/writes 0x140
    wcfg(4'd0, 32'h100); wcfg(4'd1, 32'hFF); wcfg(4'd2, 32'h0005_0000);
    wcfg(4'd3, 32'h140); wcfg(4'd4, 32'h0);  wcfg(4'd5, 32'h000D_0000);

    // R7 independent channels with priority
    wcfg(4'd8, 32'h0);
    op(0, 32'h140); expect_brk("R7 both hit ch0 wins", 1, 0, 0);
    op(1, 32'h140); expect_brk("R7 ch1 alone", 1, 1, 0);

    // R8 sequence ch0 then ch1
    wcfg(4'd8, 32'h1);
    op(1, 32'h140); expect_brk("R8 second before first", 0, 0, 0);
    op(0, 32'h104); expect_brk("R8 arming", 0, 0, 0);
    op(0, 32'h104); expect_brk("R8 first again", 0, 0, 0);
    op(1, 32'h140); expect_brk("R8 sequence complete", 1, 1, 0);
    op(1, 32'h140); expect_brk("R8 disarmed after break", 0, 0, 0);
    wcfg(4'd8, 32'h1);
    op(0, 32'h140); expect_brk("R8 same-cycle second ignored", 0, 0, 0);
    op(1, 32'h140); expect_brk("R8 armed by same-cycle hit", 1, 1, 0);

    // R8 sequence ch1 then ch0
    wcfg(4'd8, 32'h3);
    op(0, 32'h104); expect_brk("R8 order1 ch0 first", 0, 0, 0);
    op(1, 32'h140); expect_brk("R8 order1 arming", 0, 0, 0);
    op(0, 32'h104); expect_brk("R8 order1 complete", 1, 0, 0);

    // R11 configuration write disarms and masks bus cycle
    wcfg(4'd8, 32'h1);
    op(0, 32'h104);
    wcfg(4'd8, 32'h1);
    op(1, 32'h140); expect_brk("R11 write disarms", 0, 0, 0);
    cyc(1, 0, 0, 2'd2, 8'h0, 32'h104, 32'h0, 1, 4'd8, 32'h1);
    expect_brk("R11 cycle during write", 0, 0, 0);
    op(1, 32'h140); expect_brk("R11 no arm during write", 0, 0, 0);
    cyc(1, 0, 1, 2'd2, 8'h0, 32'h140, 32'h0, 1, 4'd8, 32'h0);
    expect_brk("R11 nonseq cycle ignored", 0, 0, 0);

    // R9 repeat count
    wcfg(4'd8, 32'h30);
    for (int i = 1; i <= 6; i++) begin
      op(1, 32'h140);
      expect_brk($sformatf("R9 count3 match %0d", i), (i % 3) == 0, (i % 3) == 0, 0);
    end
    wcfg(4'd8, 32'h20);
    op(1, 32'h140); expect_brk("R9 count2 first", 0, 0, 0);
    wcfg(4'd8, 32'h20);
    op(1, 32'h140); expect_brk("R9 reload by write", 0, 0, 0);
    op(1, 32'h140); expect_brk("R9 count2 reached", 1, 1, 0);

    // R12 pulse lasts one cycle
    op(0, 32'h104);
    @(negedge clk);
    expect_brk("R12 single pulse", 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule